// File: doc/BRIEF.md
# Sine-Triangle PWM Gate Generator

This block drives the four switches of a single-phase bridge with sinusoidal pulse-width modulation. A triangular carrier is made by an up/down counter that steps once per prescaler tick and turns around at zero and at its full-scale value. A half-wave sine magnitude is taken from a table that is computed when the design is elaborated. It is scaled by an unsigned amplitude word supplied from outside, and the carrier is compared against the result on every clock to form one pulse train.

The table index advances once per complete carrier period. When it wraps, a polarity flag flips, so that each half of the line period steers the pulse train to a different gate output. The two gates are therefore masked by complementary half-cycle windows whose edges line up with carrier period boundaries. Both gates are registered. They stay low during reset and for the whole first carrier period after it. The carrier and the scaled modulating value are brought out for observation. With the default parameters the carrier runs at 19.2 kHz, and 192 table steps make each 10 ms half of a 50 Hz line period.

Top module: `spwm_gate_gen`

## Requirements
- R1: The carrier resets to 0 and counts up, changes by exactly one once every DIV clocks, turns to counting down on reaching CMAX = 2^CNT_W-1 and turns to counting up on reaching 0.
- R2: One carrier period, measured from one 1-to-0 carrier step to the next, lasts 2*CMAX*DIV clocks, where DIV = max(1, CLK_HZ / (CARRIER_HZ*2*CMAX)).
- R3: Table entry k (0 <= k < HALF_STEPS, N = HALF_STEPS, u = k*(N-k)) equals floor(16*CMAX*u / (5*N*N - 4*u)). With amp_i = 2^(AMP_W-1) the modulating output equals the current entry.
- R4: The modulating output equals floor(entry*amp_i / 2^(AMP_W-1)) for the current entry, following amp_i combinationally.
- R5: The pulse train is high when carrier <= modulating value, including equality, and low when the carrier is greater.
- R6: Each gate output is registered one clock after the compare. gate_a_o carries the pulse train while the polarity flag is 0, gate_b_o carries it while the flag is 1, and each is 0 otherwise.
- R7: gate_a_o and gate_b_o are never high in the same cycle.
- R8: The table index starts at 0 and advances by one at each 1-to-0 carrier step. After entry HALF_STEPS-1 it wraps to 0 and the polarity flag toggles, so each half lasts HALF_STEPS*2*CMAX*DIV clocks.
- R9: While rst_n is low, both gates are 0, the carrier is 0 and the modulating output is that of entry 0.
- R10: Both gates stay 0 throughout the first carrier period after reset is released.
- R11: When the scaled product exceeds CMAX, the modulating output is clamped to CMAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_i | input | AMP_W | Unsigned amplitude; 2^(AMP_W-1) is unity gain |
| gate_a_o | output | 1 | Gate drive for the first-half leg pair |
| gate_b_o | output | 1 | Gate drive for the second-half leg pair |
| carrier_o | output | CNT_W | Triangle carrier value |
| mod_o | output | CNT_W | Scaled modulating value |

## Verification
The bench tracks the turning points of the carrier. A counter that overshoots CMAX, or that stalls for an extra tick at either end, fails both the step-direction check and the period check. It also checks the compare at equality, where a strict less-than would drop pulses whenever the carrier lands on the modulating value. Saturation is exercised with an amplitude near twice unity, where a missing clamp would wrap the product to a small value and collapse the pulse width. The bench times every polarity flip against the table length. It also watches the first carrier period after each reset, including one reset in the middle of a run, so a mask that is off by one carrier period, or gates that leak during start-up, show up as a mismatch on the gate whose leg would fire.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Half-wave magnitude from a rational sine approximation, peak at n/2.
  function automatic int unsigned sine_mag(int unsigned k, int unsigned n,
                                           int unsigned peak);
    int unsigned u;
    u = k * (n - k);
    return (16 * peak * u) / (5 * n * n - 4 * u);
  endfunction

  // Scale a sample by an amplitude with frac fractional bits, clamp at top.
  function automatic int unsigned scale_clamp(int unsigned s, int unsigned a,
                                              int unsigned frac,
                                              int unsigned top);
    int unsigned p;
    p = (s * a) >> frac;
    return (p > top) ? top : p;
  endfunction

endpackage

// File: rtl/spwm_tick_gen.sv
module spwm_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;

  assign tick_o = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + DW'(1);
  end
endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier
  import spwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] carrier_o,
  output logic             cyc_end_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] car_q;
  dir_e             dir_q;

  assign carrier_o = car_q;
  assign cyc_end_o = tick_i && (dir_q == DIR_DOWN) && (car_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick_i) begin
      if (dir_q == DIR_UP) begin
        car_q <= car_q + CNT_W'(1);
        if (car_q == CMAX - CNT_W'(1)) dir_q <= DIR_DOWN;
      end else begin
        car_q <= car_q - CNT_W'(1);
        if (car_q == CNT_W'(1)) dir_q <= DIR_UP;
      end
    end
  end
endmodule

// File: rtl/spwm_sine_src.sv
module spwm_sine_src
  import spwm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int AMP_W      = 8,
  parameter int HALF_STEPS = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_end_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [CNT_W-1:0] mod_o,
  output logic             half_o
);
  localparam int IDX_W = (HALF_STEPS > 1) ? $clog2(HALF_STEPS) : 1;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] rom [HALF_STEPS];
  logic [IDX_W-1:0] idx_q;
  logic             half_q;
  logic             wrap_w;

  for (genvar g = 0; g < HALF_STEPS; g++) begin : g_rom
    assign rom[g] = CNT_W'(sine_mag(g, HALF_STEPS, CMAX));
  end

  assign wrap_w = cyc_end_i && (idx_q == IDX_W'(HALF_STEPS - 1));
  assign half_o = half_q;
  assign mod_o  = CNT_W'(scale_clamp(32'(rom[idx_q]), 32'(amp_i),
                                     AMP_W - 1, CMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      half_q <= 1'b0;
    end else if (wrap_w) begin
      idx_q  <= '0;
      half_q <= ~half_q;
    end else if (cyc_end_i) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/spwm_gate_gen.sv
module spwm_gate_gen #(
  parameter int CLK_HZ     = 19_584_000,
  parameter int CARRIER_HZ = 19_200,
  parameter int CNT_W      = 8,
  parameter int AMP_W      = 8,
  parameter int HALF_STEPS = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AMP_W-1:0] amp_i,
  output logic             gate_a_o,
  output logic             gate_b_o,
  output logic [CNT_W-1:0] carrier_o,
  output logic [CNT_W-1:0] mod_o
);
  localparam int CMAX    = (1 << CNT_W) - 1;
  localparam int DIV_RAW = CLK_HZ / (CARRIER_HZ * 2 * CMAX);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic             tick_w;
  logic             cyc_end_w;
  logic             half_w;
  logic             pwm_w;
  logic             armed_q;
  logic             gate_a_q;
  logic             gate_b_q;
  logic [CNT_W-1:0] car_w;
  logic [CNT_W-1:0] mod_w;

  spwm_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  spwm_carrier #(.CNT_W(CNT_W)) u_car (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_w),
    .carrier_o (car_w),
    .cyc_end_o (cyc_end_w)
  );

  spwm_sine_src #(
    .CNT_W      (CNT_W),
    .AMP_W      (AMP_W),
    .HALF_STEPS (HALF_STEPS)
  ) u_sine (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_end_i (cyc_end_w),
    .amp_i     (amp_i),
    .mod_o     (mod_w),
    .half_o    (half_w)
  );

  assign pwm_w = (car_w <= mod_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      gate_a_q <= 1'b0;
      gate_b_q <= 1'b0;
    end else begin
      if (cyc_end_w) armed_q <= 1'b1;
      gate_a_q <= pwm_w && armed_q && !half_w;
      gate_b_q <= pwm_w && armed_q &&  half_w;
    end
  end

  assign gate_a_o  = gate_a_q;
  assign gate_b_o  = gate_b_q;
  assign carrier_o = car_w;
  assign mod_o     = mod_w;
endmodule

// File: rtl/spwm_gate_chk.sv
module spwm_gate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cyc_end,
  input logic             half,
  input logic             armed,
  input logic [CNT_W-1:0] carrier,
  input logic [CNT_W-1:0] mod,
  input logic             gate_a,
  input logic             gate_b
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1
  carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(carrier));

  // R1
  carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((carrier == $past(carrier) + CNT_W'(1)) ||
              (carrier == $past(carrier) - CNT_W'(1))));

  // R1
  top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && carrier == CMAX) |=> (carrier == CMAX - CNT_W'(1)));

  // R5
  compare_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a || gate_b) |-> ($past(carrier) <= $past(mod)));

  // R6
  side_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_a |-> !$past(half));

  // R6
  side_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_b |-> $past(half));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a && gate_b));

  // R8
  half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(half));

  // R10
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(armed) |-> (!gate_a && !gate_b));
endmodule

bind spwm_gate_gen spwm_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_w),
  .cyc_end (cyc_end_w),
  .half    (half_w),
  .armed   (armed_q),
  .carrier (car_w),
  .mod     (mod_w),
  .gate_a  (gate_a_o),
  .gate_b  (gate_b_o)
);

// File: tb/sim_spwm_gate_gen.sv
module sim_spwm_gate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 60_000;
  localparam int CARRIER_HZ = 1_000;
  localparam int CNT_W      = 4;
  localparam int AMP_W      = 8;
  localparam int HALF       = 8;
  localparam int CMAX       = (1 << CNT_W) - 1;
  localparam int DIV        = CLK_HZ / (CARRIER_HZ * 2 * CMAX);
  localparam int PER        = 2 * CMAX * DIV;
  localparam int HALF_CLK   = HALF * PER;
  localparam int UNITY      = 1 << (AMP_W - 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [AMP_W-1:0] amp = AMP_W'(UNITY);
  logic             gate_a, gate_b;
  logic [CNT_W-1:0] car, modv;

  spwm_gate_gen #(
    .CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .CNT_W(CNT_W),
    .AMP_W(AMP_W), .HALF_STEPS(HALF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .amp_i(amp), .gate_a_o(gate_a),
    .gate_b_o(gate_b), .carrier_o(car), .mod_o(modv)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] exp_q[$];

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Table entry written from the requirement formula (R3).
  function automatic int ref_entry(int k);
    int q;
    q = HALF * k - k * k;
    return (CMAX * 16 * q) / (5 * HALF * HALF - 4 * q);
  endfunction

  function automatic int ref_raw(int k, int a);
    return (ref_entry(k) * a) / UNITY;
  endfunction

  function automatic int ref_mod(int k, int a);
    int r;
    r = ref_raw(k, a);
    if (r > CMAX) r = CMAX;
    return r;
  endfunction

  task automatic push_expect(logic ea, logic eb);
    exp_q.push_back({ea, eb});
  endtask

  // Scoreboard model state, built only from port observations.
  int b_idx, since_step, since_cyc, since_half, prev_car, first_hi;
  int eq_hits, sat_hits;
  bit b_up, b_half, b_armed;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R9
      check(gate_a == 1'b0 && gate_b == 1'b0, "R9 gates in reset", {gate_a, gate_b}, 0);
      check(int'(car) == 0, "R9 carrier in reset", int'(car), 0);
      check(int'(modv) == ref_mod(0, int'(amp)), "R9 mod in reset", int'(modv), ref_mod(0, int'(amp)));
      b_idx = 0; b_half = 0; b_armed = 0; b_up = 1;
      since_step = 0; since_cyc = 0; since_half = 0; prev_car = 0; first_hi = 0;
      exp_q.delete();
    end else begin
      int em, cv;
      logic pw;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        e = exp_q.pop_front();
        // R6
        check(gate_a == e[1], "R6 gate_a", gate_a, e[1]);
        check(gate_b == e[0], "R6 gate_b", gate_b, e[0]);
      end
      // R7
      check(!(gate_a && gate_b), "R7 overlap", {gate_a, gate_b}, 0);
      if (!b_armed && (gate_a || gate_b)) first_hi++;
      cv = int'(car);
      since_step++; since_cyc++; since_half++;
      if (cv != prev_car) begin
        // R1
        check(since_step == DIV, "R1 step spacing", since_step, DIV);
        check(cv == (b_up ? prev_car + 1 : prev_car - 1), "R1 step value",
              cv, b_up ? prev_car + 1 : prev_car - 1);
        since_step = 0;
        if (cv == CMAX) b_up = 0;
        else if (cv == 0) b_up = 1;
        if (prev_car == 1 && cv == 0) begin
          // R2
          check(since_cyc == PER, "R2 carrier period", since_cyc, PER);
          since_cyc = 0;
          // R10
          if (!b_armed) check(first_hi == 0, "R10 first period quiet", first_hi, 0);
          b_armed = 1;
          if (b_idx == HALF - 1) begin
            b_idx = 0;
            b_half = !b_half;
            // R8
            check(since_half == HALF_CLK, "R8 half length", since_half, HALF_CLK);
            since_half = 0;
          end else begin
            b_idx++;
          end
        end
      end else if (since_step > DIV) begin
        check(1'b0, "R1 carrier stalled", since_step, DIV);
      end
      em = ref_mod(b_idx, int'(amp));
      if (ref_raw(b_idx, int'(amp)) > CMAX) begin
        // R11
        check(int'(modv) == CMAX, "R11 clamp", int'(modv), CMAX);
        if (int'(modv) == CMAX) sat_hits++;
      end else if (int'(amp) == UNITY) begin
        // R3
        check(int'(modv) == ref_entry(b_idx), "R3 table entry", int'(modv), ref_entry(b_idx));
      end else begin
        // R4
        check(int'(modv) == em, "R4 scaled value", int'(modv), em);
      end
      pw = (cv <= em);
      if (cv == em && b_armed) eq_hits++;
      push_expect(pw && b_armed && !b_half, pw && b_armed && b_half);
      prev_car = cv;
    end
  end

  task automatic run(int a, int cycles);
    @(posedge clk); #1 amp = AMP_W'(a);
    repeat (cycles) @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    run(UNITY, 4 * HALF_CLK);      // R3 R8 R10 at unity gain
    run(64, 1000);                 // R4 half gain
    run(255, 1000);                // R11 overmodulation
    run(0, 300);                   // R5 zero amplitude, equality at carrier 0
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    run(200, 1500);                // R10 after mid-run reset, R11
    @(negedge clk);
    // R5
    check(eq_hits > 0, "R5 equality compared", eq_hits, 1);
    // R11
    check(sat_hits > 0, "R11 saturation seen", sat_hits, 1);
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200_000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule